// File: doc/BRIEF.md
# Three-Port Latchable Bus Multiplexer

This block moves 9-bit words between three ports, A, B and C. A two-bit select picks the source port. The source can feed one or both of the other ports, and each port has its own active-low output-enable. Every route passes through one of four path latches: A toward C, B toward C, C toward A and C toward B. Transfers between A and B reuse the C-side latch of the source port. Each latch is either transparent or holding, so software-visible traffic can be passed straight through or frozen while the source port changes. Bit 8 of each word is a parity bit. A parity-invert control flips that bit on words leaving the C port toward A or B, which lets a system force parity errors for diagnostics.

A port can read back the word its own path latch captured earlier. This is how a system checks that a value was taken correctly. Readback is only legal while the latch is holding. If readback is requested through a transparent latch, the block raises a loop-error flag and keeps the port undriven, so no combinational loop forms. Readback of C borrows the A path (select 10) or the B path (select 11), and that port is silenced while C reads back.

The latches are modelled in a clocked chip fabric. While a hold input is low, the latch output follows its input combinationally, and the value is recorded at every rising clock edge. While the hold input is high, the latch outputs the value recorded at the last rising edge at which hold was low. Each port appears as a separate input bus, output bus and drive flag.

Top module: `tri_port_bus_mux`

## Requirements
- R1: After reset every path latch stores zero, so a holding latch presents 0 until it captures data.
- R2: With sel=00 (source A), B drives the A-to-C latch value when b_oe_n=0, and C drives it when c_oe_n=0.
- R3: With sel=01 (source B), A and C drive the B-to-C latch value when their own enable is low.
- R4: With sel=10 or sel=11 (source C), A drives the C-to-A latch value and B drives the C-to-B latch value. Bit 8 is inverted on both when par_inv=1 and passed unchanged when par_inv=0.
- R5: While its hold input is 0, a latch output equals its input in the same cycle. While hold is 1, the latch output is the input seen at the last rising edge at which hold was 0.
- R6: A port drives (its _drv output is 1) only when its own enable is low and the rules in R2 to R9 allow it. With all three enables high, no port drives.
- R7: With sel=00, a_oe_n=0 and hold_ac=1, A drives its own A-to-C latch value. With sel=01, b_oe_n=0 and hold_bc=1, B drives its B-to-C latch value. In both cases the other ports behave as in R2 and R3.
- R8: With c_oe_n=0, C reads back unchanged data (no parity inversion) from the C-to-A latch when sel=10 or from the C-to-B latch when sel=11. While this happens, A (sel=10) or B (sel=11) does not drive.
- R9: loop_err is 1 exactly when the port being read back has its enable low and its latch is transparent (hold=0). That port then does not drive.
- R10: A port that does not drive outputs all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that records latch contents |
| rst_n | input | 1 | Active-low reset, clears latch contents |
| a_in | input | 9 | Word arriving at port A |
| b_in | input | 9 | Word arriving at port B |
| c_in | input | 9 | Word arriving at port C |
| sel | input | 2 | Source select: 00 A, 01 B, 10 C via A side, 11 C via B side |
| a_oe_n | input | 1 | Port A output-enable, active low |
| b_oe_n | input | 1 | Port B output-enable, active low |
| c_oe_n | input | 1 | Port C output-enable, active low |
| hold_ac | input | 1 | Hold for the A-to-C latch (1 = hold) |
| hold_bc | input | 1 | Hold for the B-to-C latch |
| hold_ca | input | 1 | Hold for the C-to-A latch |
| hold_cb | input | 1 | Hold for the C-to-B latch |
| par_inv | input | 1 | Invert bit 8 on words from C toward A or B |
| a_out | output | 9 | Word driven on port A |
| a_drv | output | 1 | Port A is driving |
| b_out | output | 9 | Word driven on port B |
| b_drv | output | 1 | Port B is driving |
| c_out | output | 9 | Word driven on port C |
| c_drv | output | 1 | Port C is driving |
| loop_err | output | 1 | Readback requested through a transparent latch |

## Verification
Every output is combinational from the inputs and the recorded latch contents. Routing, parity inversion, drive flags and loop_err are therefore due in the same cycle the controls change. A recorded value is due only after a rising edge at which the hold input was low. For each sweep point, the bench captures a first data set at a rising edge with all holds low. On the next falling edge it applies the new controls and a second data set, then samples 5 ns later, before the next rising edge. The expected word for each latch is the first data set if that latch holds and the second if it is transparent.

// File: rtl/tpbm_pkg.sv
package tpbm_pkg;
    localparam int DATA_W  = 9;
    localparam int N_PATHS = 4;

    typedef enum logic [1:0] {
        SRC_A    = 2'b00,
        SRC_B    = 2'b01,
        SRC_C_VA = 2'b10,
        SRC_C_VB = 2'b11
    } src_sel_e;

    localparam int P_AC = 0;
    localparam int P_BC = 1;
    localparam int P_CA = 2;
    localparam int P_CB = 3;
endpackage

// File: rtl/tpbm_path_latch.sv
module tpbm_path_latch #(
    parameter int W = tpbm_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] keep_d, keep_q;

    always_comb begin
        keep_d = hold ? keep_q : din;
        dout   = hold ? keep_q : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) keep_q <= '0;
        else        keep_q <= keep_d;
    end
endmodule

// File: rtl/tpbm_router.sv
module tpbm_router
    import tpbm_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int P = N_PATHS
) (
    input  logic [1:0]       sel,
    input  logic             a_oe_n,
    input  logic             b_oe_n,
    input  logic             c_oe_n,
    input  logic             par_inv,
    input  logic [P-1:0]     hold_v,
    input  logic [W-1:0]     lat [P],
    output logic [W-1:0]     a_out,
    output logic             a_drv,
    output logic [W-1:0]     b_out,
    output logic             b_drv,
    output logic [W-1:0]     c_out,
    output logic             c_drv,
    output logic             loop_err
);
    localparam logic [W-1:0] PAR_MASK = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] flip;
    logic [W-1:0] a_w, b_w, c_w;

    always_comb begin
        flip     = par_inv ? PAR_MASK : '0;
        a_w      = '0;
        b_w      = '0;
        c_w      = '0;
        a_drv    = 1'b0;
        b_drv    = 1'b0;
        c_drv    = 1'b0;
        loop_err = 1'b0;
        unique case (src_sel_e'(sel))
            SRC_A: begin
                a_w      = lat[P_AC];
                b_w      = lat[P_AC];
                c_w      = lat[P_AC];
                a_drv    = !a_oe_n && hold_v[P_AC];
                b_drv    = !b_oe_n;
                c_drv    = !c_oe_n;
                loop_err = !a_oe_n && !hold_v[P_AC];
            end
            SRC_B: begin
                a_w      = lat[P_BC];
                b_w      = lat[P_BC];
                c_w      = lat[P_BC];
                a_drv    = !a_oe_n;
                b_drv    = !b_oe_n && hold_v[P_BC];
                c_drv    = !c_oe_n;
                loop_err = !b_oe_n && !hold_v[P_BC];
            end
            SRC_C_VA: begin
                a_w      = lat[P_CA] ^ flip;
                b_w      = lat[P_CB] ^ flip;
                c_w      = lat[P_CA];
                a_drv    = !a_oe_n && c_oe_n;
                b_drv    = !b_oe_n;
                c_drv    = !c_oe_n && hold_v[P_CA];
                loop_err = !c_oe_n && !hold_v[P_CA];
            end
            SRC_C_VB: begin
                a_w      = lat[P_CA] ^ flip;
                b_w      = lat[P_CB] ^ flip;
                c_w      = lat[P_CB];
                a_drv    = !a_oe_n;
                b_drv    = !b_oe_n && c_oe_n;
                c_drv    = !c_oe_n && hold_v[P_CB];
                loop_err = !c_oe_n && !hold_v[P_CB];
            end
            default: ;
        endcase
        a_out = a_drv ? a_w : '0;
        b_out = b_drv ? b_w : '0;
        c_out = c_drv ? c_w : '0;
    end
endmodule

// File: rtl/tri_port_bus_mux.sv
module tri_port_bus_mux
    import tpbm_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] c_in,
    input  logic [1:0]   sel,
    input  logic         a_oe_n,
    input  logic         b_oe_n,
    input  logic         c_oe_n,
    input  logic         hold_ac,
    input  logic         hold_bc,
    input  logic         hold_ca,
    input  logic         hold_cb,
    input  logic         par_inv,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    output logic [W-1:0] c_out,
    output logic         c_drv,
    output logic         loop_err
);
    localparam int P = N_PATHS;

    logic [P-1:0] hold_v;
    logic [W-1:0] path_in  [P];
    logic [W-1:0] path_out [P];

    always_comb begin
        hold_v[P_AC]  = hold_ac;
        hold_v[P_BC]  = hold_bc;
        hold_v[P_CA]  = hold_ca;
        hold_v[P_CB]  = hold_cb;
        path_in[P_AC] = a_in;
        path_in[P_BC] = b_in;
        path_in[P_CA] = c_in;
        path_in[P_CB] = c_in;
    end

    for (genvar g = 0; g < P; g++) begin : g_path
        tpbm_path_latch #(.W(W)) i_latch (
            .clk  (clk),
            .rst_n(rst_n),
            .hold (hold_v[g]),
            .din  (path_in[g]),
            .dout (path_out[g])
        );
    end

    tpbm_router #(.W(W), .P(P)) i_router (
        .sel     (sel),
        .a_oe_n  (a_oe_n),
        .b_oe_n  (b_oe_n),
        .c_oe_n  (c_oe_n),
        .par_inv (par_inv),
        .hold_v  (hold_v),
        .lat     (path_out),
        .a_out   (a_out),
        .a_drv   (a_drv),
        .b_out   (b_out),
        .b_drv   (b_drv),
        .c_out   (c_out),
        .c_drv   (c_drv),
        .loop_err(loop_err)
    );
endmodule

// File: rtl/tpbm_checker.sv
module tpbm_checker #(
    parameter int W = tpbm_pkg::DATA_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] c_in,
    input logic [1:0]   sel,
    input logic         a_oe_n,
    input logic         b_oe_n,
    input logic         c_oe_n,
    input logic         hold_ac,
    input logic         hold_ca,
    input logic         par_inv,
    input logic [W-1:0] a_out,
    input logic         a_drv,
    input logic [W-1:0] b_out,
    input logic         b_drv,
    input logic [W-1:0] c_out,
    input logic         c_drv,
    input logic         loop_err
);
    assert_transparent_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00 && !hold_ac && b_drv) |-> (b_out == a_in));

    assert_held_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10 && $past(sel) == 2'b10 && hold_ca && $past(hold_ca) && c_drv && $past(c_drv))
        |-> $stable(c_out));

    assert_parity_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10 && !hold_ca && a_drv) |-> (a_out[W-1] == (c_in[W-1] ^ par_inv)));

    assert_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe_n && b_oe_n && c_oe_n) |-> !(a_drv || b_drv || c_drv));

    assert_loop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_err && sel == 2'b00) |-> !a_drv);

    assert_c_rb_mutes_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10 && c_drv) |-> !a_drv);

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_drv |-> a_out == '0) and (!b_drv |-> b_out == '0) and (!c_drv |-> c_out == '0));
endmodule

bind tri_port_bus_mux tpbm_checker #(.W(W)) i_chk (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .c_in(c_in), .sel(sel),
    .a_oe_n(a_oe_n), .b_oe_n(b_oe_n), .c_oe_n(c_oe_n),
    .hold_ac(hold_ac), .hold_ca(hold_ca), .par_inv(par_inv),
    .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
    .c_out(c_out), .c_drv(c_drv), .loop_err(loop_err)
);

// File: tb/test_tri_port_bus_mux.sv
module test_tri_port_bus_mux;
    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0, c_in = '0;
    logic [1:0]   sel = 2'b00;
    logic         a_oe_n = 1'b1, b_oe_n = 1'b1, c_oe_n = 1'b1;
    logic         hold_ac = 1'b0, hold_bc = 1'b0, hold_ca = 1'b0, hold_cb = 1'b0;
    logic         par_inv = 1'b0;
    logic [W-1:0] a_out, b_out, c_out;
    logic         a_drv, b_drv, c_drv, loop_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tri_port_bus_mux #(.W(W)) i_tri_port_bus_mux (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .sel(sel), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n), .c_oe_n(c_oe_n),
        .hold_ac(hold_ac), .hold_bc(hold_bc), .hold_ca(hold_ca), .hold_cb(hold_cb),
        .par_inv(par_inv), .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
        .c_out(c_out), .c_drv(c_drv), .loop_err(loop_err)
    );

    task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h sel=%b oe_n=%b%b%b hold=%b%b%b%b par=%b",
                     tag, act, exp, sel, a_oe_n, b_oe_n, c_oe_n,
                     hold_ac, hold_bc, hold_ca, hold_cb, par_inv);
        end
    endtask

    function automatic logic [W-1:0] pat(input int k, input int salt);
        return W'((k * 37 + salt * 101 + 5) % 512);
    endfunction

    initial begin
        // R1: reset clears latch contents; holding C-to-A latch reads back 0
        @(negedge clk);
        a_in = 9'h1A5; b_in = 9'h0F3; c_in = 9'h16C;
        hold_ac = 1'b1; hold_bc = 1'b1; hold_ca = 1'b1; hold_cb = 1'b1;
        sel = 2'b10; c_oe_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk); #5;
        check("R1 c readback after reset", {c_drv, c_out}, {1'b1, 9'h000});
        sel = 2'b11; #1;
        check("R1 cb latch after reset", {c_drv, c_out}, {1'b1, 9'h000});
        c_oe_n = 1'b1;

        // Sweep every select, enable, hold and parity setting
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 8; o++) begin
                for (int h = 0; h < 16; h++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic [W-1:0] a1, b1, c1, a2, b2, c2;
                        logic [W-1:0] eac, ebc, eca, ecb, fl;
                        logic [W:0]   ea, eb, ec;
                        logic         ee;
                        logic         aon, bon, con;
                        int           idx;
                        idx = ((s * 8 + o) * 16 + h) * 2 + p;
                        a1 = pat(idx, 1); b1 = pat(idx, 2); c1 = pat(idx, 3);
                        a2 = pat(idx, 4); b2 = pat(idx, 5); c2 = pat(idx, 6);
                        @(negedge clk);
                        hold_ac = 1'b0; hold_bc = 1'b0; hold_ca = 1'b0; hold_cb = 1'b0;
                        a_in = a1; b_in = b1; c_in = c1;
                        @(posedge clk);
                        @(negedge clk);
                        sel = s[1:0];
                        a_oe_n = o[0]; b_oe_n = o[1]; c_oe_n = o[2];
                        hold_ac = h[0]; hold_bc = h[1]; hold_ca = h[2]; hold_cb = h[3];
                        par_inv = p[0];
                        a_in = a2; b_in = b2; c_in = c2;
                        #5;
                        // R5: held latch keeps edge-captured word, open latch follows input
                        eac = h[0] ? a1 : a2;
                        ebc = h[1] ? b1 : b2;
                        eca = h[2] ? c1 : c2;
                        ecb = h[3] ? c1 : c2;
                        fl  = p[0] ? 9'h100 : 9'h000;
                        aon = !o[0]; bon = !o[1]; con = !o[2];
                        ea = '0; eb = '0; ec = '0; ee = 1'b0;
                        case (s)
                            0: begin
                                ee = aon && !h[0];
                                if (aon && h[0]) ea = {1'b1, eac};
                                if (bon) eb = {1'b1, eac};
                                if (con) ec = {1'b1, eac};
                            end
                            1: begin
                                ee = bon && !h[1];
                                if (aon) ea = {1'b1, ebc};
                                if (bon && h[1]) eb = {1'b1, ebc};
                                if (con) ec = {1'b1, ebc};
                            end
                            2: begin
                                ee = con && !h[2];
                                if (aon && !con) ea = {1'b1, eca ^ fl};
                                if (bon) eb = {1'b1, ecb ^ fl};
                                if (con && h[2]) ec = {1'b1, eca};
                            end
                            default: begin
                                ee = con && !h[3];
                                if (aon) ea = {1'b1, eca ^ fl};
                                if (bon && !con) eb = {1'b1, ecb ^ fl};
                                if (con && h[3]) ec = {1'b1, ecb};
                            end
                        endcase
                        case (s)
                            0: begin
                                check("R7 port A readback", {a_drv, a_out}, ea);
                                check("R2 A to B", {b_drv, b_out}, eb);
                                check("R2 A to C", {c_drv, c_out}, ec);
                            end
                            1: begin
                                check("R3 B to A", {a_drv, a_out}, ea);
                                check("R7 port B readback", {b_drv, b_out}, eb);
                                check("R3 B to C", {c_drv, c_out}, ec);
                            end
                            default: begin
                                check("R4 C to A with parity", {a_drv, a_out}, ea);
                                check("R4 C to B with parity", {b_drv, b_out}, eb);
                                check("R8 port C readback", {c_drv, c_out}, ec);
                            end
                        endcase
                        check("R9 loop error flag", {{W{1'b0}}, loop_err}, {{W{1'b0}}, ee});
                    end
                end
            end
        end

        // R6 and R10: all enables high, nothing driven, all outputs zero
        @(negedge clk);
        a_oe_n = 1'b1; b_oe_n = 1'b1; c_oe_n = 1'b1; sel = 2'b01; #5;
        check("R6 idle A", {a_drv, a_out}, '0);
        check("R10 idle B", {b_drv, b_out}, '0);
        check("R6 idle C", {c_drv, c_out}, '0);

        // R5 directed: hold across several edges keeps first captured word
        @(negedge clk);
        sel = 2'b00; hold_ac = 1'b0; b_oe_n = 1'b0; a_in = 9'h155;
        @(posedge clk); @(negedge clk);
        hold_ac = 1'b1; a_in = 9'h0AA;
        repeat (3) @(posedge clk);
        @(negedge clk); #5;
        check("R5 multi-edge hold", {b_drv, b_out}, {1'b1, 9'h155});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule